// File: doc/BRIEF.md
# Pulse-Disciplined Timestamp Counter

This block keeps absolute time inside the fabric so that I/O activity can be stamped with a seconds-and-ticks value. Time has two parts: a whole-seconds count and a sub-second tick count driven by the local fabric clock, nominally 40 MHz. A once-per-second reference pulse arrives from outside the device on an asynchronous, input-only trigger line. The block never drives that line.

While the pulse is low, host software writes the upcoming whole-second value into a preload register. That write does not change the running time. On the next accepted rising edge of the pulse, the preloaded value becomes the current second and the tick count restarts at zero. If no pulse arrives, the tick counter wraps on its own and the seconds count advances. If no preload was written since the last edge, the block advances the seconds itself. In both cases a sticky flag records the event. A programmable glitch guard drops edges that arrive too soon after the last accepted one and counts how many it dropped. A capture strobe copies the seconds and ticks of one clock cycle into a holding register.

Top module: `pulse_timebase`

## Requirements
- R1: While rst_ni is low, every output is zero: time, capture, flags and rejection count.
- R2: The trigger passes through a two-stage synchronizer. When trig_i rises before a clock edge, the commit shows on the outputs after the third rising clock edge. A trigger held high for many cycles commits only once.
- R3: On an accepted edge with a pending preload, time_sec_o takes the preloaded value and time_tick_o goes to 0. A preload write with no edge leaves time_sec_o unchanged.
- R4: Outside of edges, time_tick_o steps by one each cycle, from 0 up to TPS-1, and never leaves that range.
- R5: trig_seen_o stays 0 until the first accepted edge. After that it stays 1 until reset.
- R6: On an accepted edge with no preload written since the previous accepted edge, time_sec_o increments by one and pre_miss_o is set. A preload write clears pre_miss_o, but a set in the same cycle wins.
- R7: When time_tick_o is TPS-1 and no edge is accepted, ticks wrap to 0, time_sec_o increments and pulse_miss_o is set. A preload write clears pulse_miss_o. An edge accepted in the terminal-tick cycle takes priority: it loads time and leaves pulse_miss_o alone.
- R8: An edge is rejected if it arrives less than min_gap_i cycles after the previous accepted edge. The first edge after reset is always accepted. A rejected edge leaves time and flags alone, and it adds one to rej_cnt_o, which saturates at all ones.
- R9: One cycle after a cycle with evt_i high, cap_sec_o and cap_tick_o hold the time_sec_o and time_tick_o that were present in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fabric clock, the tick source |
| rst_ni | input | 1 | Active-low asynchronous reset |
| trig_i | input | 1 | Asynchronous once-per-second reference pulse, never driven |
| pre_val_i | input | SEC_W | Next whole-second value from the host |
| pre_we_i | input | 1 | Preload write strobe, also clears both missing flags |
| min_gap_i | input | TICK_W | Minimum cycles between accepted edges |
| evt_i | input | 1 | Capture strobe |
| time_sec_o | output | SEC_W | Current seconds |
| time_tick_o | output | TICK_W | Current sub-second ticks |
| cap_sec_o | output | SEC_W | Captured seconds |
| cap_tick_o | output | TICK_W | Captured ticks |
| trig_seen_o | output | 1 | Sticky: an edge has been accepted |
| pre_miss_o | output | 1 | Sticky: an edge found no preload |
| pulse_miss_o | output | 1 | Sticky: ticks wrapped without a pulse |
| rej_cnt_o | output | REJ_W | Saturating count of rejected edges |

## Verification
The assertions take the host inputs to be synchronous to clk_i: one-cycle pre_we_i and evt_i strobes, and a min_gap_i that only changes while no edge is pending. Only trig_i may be asynchronous. The stimulus meets these conditions by driving every input on the falling clock edge. It also keeps min_gap_i well below the saturation value of the gap counter. Trigger pulses come both closer together and farther apart than the guard window, and one edge is placed on the terminal tick.

// File: rtl/ptb_pkg.sv
package ptb_pkg;
  typedef enum logic [1:0] {
    SEC_HOLD,
    SEC_LOAD,
    SEC_INC
  } sec_op_e;
endpackage

// File: rtl/ptb_edge_det.sv
module ptb_edge_det #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q[0] <= 1'b0;
    else         sync_q[0] <= async_i;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sync_q[i] <= 1'b0;
      else         sync_q[i] <= sync_q[i-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sync_q[STAGES-1];
  end

  assign rise_o = sync_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/ptb_glitch_guard.sv
module ptb_glitch_guard #(
  parameter int unsigned GAP_W = 26,
  parameter int unsigned REJ_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rise_i,
  input  logic [GAP_W-1:0] min_gap_i,
  output logic             accept_o,
  output logic             reject_o,
  output logic [REJ_W-1:0] rej_cnt_o
);
  logic [GAP_W-1:0] gap_q;
  logic             have_q;
  logic [REJ_W-1:0] rej_q;

  assign accept_o  = rise_i & (~have_q | (gap_q >= min_gap_i));
  assign reject_o  = rise_i & ~accept_o;
  assign rej_cnt_o = rej_q;

  // gap_q holds cycles elapsed since the last accepted edge, saturating
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q  <= '0;
      have_q <= 1'b0;
      rej_q  <= '0;
    end else begin
      if (accept_o)    gap_q <= GAP_W'(1);
      else if (~&gap_q) gap_q <= gap_q + 1'b1;
      if (accept_o)    have_q <= 1'b1;
      if (reject_o && ~&rej_q) rej_q <= rej_q + 1'b1;
    end
  end
endmodule

// File: rtl/ptb_time_core.sv
module ptb_time_core
  import ptb_pkg::*;
#(
  parameter int unsigned SEC_W  = 32,
  parameter int unsigned TPS    = 40_000_000,
  parameter int unsigned TICK_W = $clog2(TPS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic [SEC_W-1:0]  pre_val_i,
  input  logic              pre_we_i,
  output logic [SEC_W-1:0]  sec_o,
  output logic [TICK_W-1:0] tick_o,
  output logic [SEC_W-1:0]  pre_q_o,
  output logic              pend_o,
  output logic              seen_o,
  output logic              pre_miss_o,
  output logic              pulse_miss_o
);
  localparam logic [TICK_W-1:0] TICK_LAST = TICK_W'(TPS - 1);

  logic [SEC_W-1:0]  sec_q, pre_q;
  logic [TICK_W-1:0] tick_q;
  logic              pend_q, seen_q, pmiss_q, wmiss_q;
  logic              wrap;
  sec_op_e           sec_op;

  assign wrap = ~accept_i & (tick_q == TICK_LAST);

  always_comb begin
    sec_op = SEC_HOLD;
    if (accept_i)  sec_op = pend_q ? SEC_LOAD : SEC_INC;
    else if (wrap) sec_op = SEC_INC;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sec_q  <= '0;
      tick_q <= '0;
    end else begin
      unique case (sec_op)
        SEC_LOAD: sec_q <= pre_q;
        SEC_INC:  sec_q <= sec_q + 1'b1;
        default:  sec_q <= sec_q;
      endcase
      if (accept_i || wrap) tick_q <= '0;
      else                  tick_q <= tick_q + 1'b1;
    end
  end

  // preload is owned by the next accepted edge; a same-cycle write waits for the one after
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      if (pre_we_i) begin
        pre_q  <= pre_val_i;
        pend_q <= 1'b1;
      end else if (accept_i) begin
        pend_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q  <= 1'b0;
      pmiss_q <= 1'b0;
      wmiss_q <= 1'b0;
    end else begin
      if (accept_i) seen_q <= 1'b1;
      if (accept_i && !pend_q) pmiss_q <= 1'b1;
      else if (pre_we_i)       pmiss_q <= 1'b0;
      if (wrap)          wmiss_q <= 1'b1;
      else if (pre_we_i) wmiss_q <= 1'b0;
    end
  end

  assign sec_o        = sec_q;
  assign tick_o       = tick_q;
  assign pre_q_o      = pre_q;
  assign pend_o       = pend_q;
  assign seen_o       = seen_q;
  assign pre_miss_o   = pmiss_q;
  assign pulse_miss_o = wmiss_q;
endmodule

// File: rtl/ptb_capture.sv
module ptb_capture #(
  parameter int unsigned SEC_W  = 32,
  parameter int unsigned TICK_W = 26
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              evt_i,
  input  logic [SEC_W-1:0]  sec_i,
  input  logic [TICK_W-1:0] tick_i,
  output logic [SEC_W-1:0]  cap_sec_o,
  output logic [TICK_W-1:0] cap_tick_o
);
  localparam int unsigned CAP_W = SEC_W + TICK_W;

  // one register for both halves keeps them from the same cycle
  logic [CAP_W-1:0] cap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cap_q <= '0;
    else if (evt_i) cap_q <= {sec_i, tick_i};
  end

  assign {cap_sec_o, cap_tick_o} = cap_q;
endmodule

// File: rtl/pulse_timebase.sv
module pulse_timebase #(
  parameter int unsigned SEC_W       = 32,
  parameter int unsigned TPS         = 40_000_000,
  parameter int unsigned REJ_W       = 16,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned TICK_W      = $clog2(TPS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              trig_i,
  input  logic [SEC_W-1:0]  pre_val_i,
  input  logic              pre_we_i,
  input  logic [TICK_W-1:0] min_gap_i,
  input  logic              evt_i,
  output logic [SEC_W-1:0]  time_sec_o,
  output logic [TICK_W-1:0] time_tick_o,
  output logic [SEC_W-1:0]  cap_sec_o,
  output logic [TICK_W-1:0] cap_tick_o,
  output logic              trig_seen_o,
  output logic              pre_miss_o,
  output logic              pulse_miss_o,
  output logic [REJ_W-1:0]  rej_cnt_o
);
  logic              rise, accept, reject, pend;
  logic [SEC_W-1:0]  sec, pre_q;
  logic [TICK_W-1:0] tick;

  // trig_i is sampled only; nothing in the block drives the line
  ptb_edge_det #(.STAGES(SYNC_STAGES)) u_edge (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (trig_i),
    .rise_o  (rise)
  );

  ptb_glitch_guard #(.GAP_W(TICK_W), .REJ_W(REJ_W)) u_guard (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rise_i    (rise),
    .min_gap_i (min_gap_i),
    .accept_o  (accept),
    .reject_o  (reject),
    .rej_cnt_o (rej_cnt_o)
  );

  ptb_time_core #(.SEC_W(SEC_W), .TPS(TPS), .TICK_W(TICK_W)) u_core (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .accept_i     (accept),
    .pre_val_i    (pre_val_i),
    .pre_we_i     (pre_we_i),
    .sec_o        (sec),
    .tick_o       (tick),
    .pre_q_o      (pre_q),
    .pend_o       (pend),
    .seen_o       (trig_seen_o),
    .pre_miss_o   (pre_miss_o),
    .pulse_miss_o (pulse_miss_o)
  );

  ptb_capture #(.SEC_W(SEC_W), .TICK_W(TICK_W)) u_cap (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .evt_i      (evt_i),
    .sec_i      (sec),
    .tick_i     (tick),
    .cap_sec_o  (cap_sec_o),
    .cap_tick_o (cap_tick_o)
  );

  assign time_sec_o  = sec;
  assign time_tick_o = tick;
endmodule

// File: rtl/ptb_checker.sv
module ptb_checker #(
  parameter int unsigned SEC_W  = 32,
  parameter int unsigned TPS    = 40_000_000,
  parameter int unsigned REJ_W  = 16,
  parameter int unsigned TICK_W = $clog2(TPS)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rise,
  input logic              accept,
  input logic              reject,
  input logic              pend,
  input logic [SEC_W-1:0]  pre_q,
  input logic              evt_i,
  input logic [SEC_W-1:0]  time_sec_o,
  input logic [TICK_W-1:0] time_tick_o,
  input logic [SEC_W-1:0]  cap_sec_o,
  input logic [TICK_W-1:0] cap_tick_o,
  input logic              trig_seen_o,
  input logic              pre_miss_o,
  input logic              pulse_miss_o,
  input logic [REJ_W-1:0]  rej_cnt_o
);
  localparam logic [TICK_W-1:0] TICK_LAST = TICK_W'(TPS - 1);

  AST_STROBE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise |=> !rise); // R2

  AST_LOAD_PRELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && pend |=> time_sec_o == $past(pre_q) && time_tick_o == '0); // R3

  AST_TICK_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    time_tick_o <= TICK_LAST); // R4

  AST_TICK_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !accept && time_tick_o != TICK_LAST |=> time_tick_o == $past(time_tick_o) + TICK_W'(1)); // R4

  AST_SEEN_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_seen_o |=> trig_seen_o); // R5

  AST_SEEN_ONLY_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !trig_seen_o && !accept |=> !trig_seen_o); // R5

  AST_NO_PRELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && !pend |=> time_sec_o == $past(time_sec_o) + SEC_W'(1) && pre_miss_o); // R6

  AST_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !accept && time_tick_o == TICK_LAST |=>
      time_tick_o == '0 && time_sec_o == $past(time_sec_o) + SEC_W'(1) && pulse_miss_o); // R7

  AST_REJECT_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reject && rej_cnt_o != '1 |=> rej_cnt_o == $past(rej_cnt_o) + REJ_W'(1)); // R8

  AST_REJECT_TIME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reject && time_tick_o != TICK_LAST |=> $stable(time_sec_o)); // R8

  AST_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_i |=> cap_sec_o == $past(time_sec_o) && cap_tick_o == $past(time_tick_o)); // R9
endmodule

bind pulse_timebase ptb_checker #(
  .SEC_W(SEC_W), .TPS(TPS), .REJ_W(REJ_W), .TICK_W(TICK_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .rise         (rise),
  .accept       (accept),
  .reject       (reject),
  .pend         (pend),
  .pre_q        (pre_q),
  .evt_i        (evt_i),
  .time_sec_o   (time_sec_o),
  .time_tick_o  (time_tick_o),
  .cap_sec_o    (cap_sec_o),
  .cap_tick_o   (cap_tick_o),
  .trig_seen_o  (trig_seen_o),
  .pre_miss_o   (pre_miss_o),
  .pulse_miss_o (pulse_miss_o),
  .rej_cnt_o    (rej_cnt_o)
);

// File: tb/pulse_timebase_tb_top.sv
module pulse_timebase_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int TPS    = 100;
  localparam int SEC_W  = 32;
  localparam int REJ_W  = 3;
  localparam int TW     = $clog2(TPS);
  localparam int GAP_MAX = (1 << TW) - 1;
  localparam int REJ_MAX = (1 << REJ_W) - 1;

  logic             clk = 0;
  logic             rst_n = 0;
  logic             trig = 0;
  logic [SEC_W-1:0] pre_val = '0;
  logic             pre_we = 0;
  logic [TW-1:0]    min_gap = '0;
  logic             evt = 0;
  logic [SEC_W-1:0] time_sec, cap_sec;
  logic [TW-1:0]    time_tick, cap_tick;
  logic             seen, pre_miss, pulse_miss;
  logic [REJ_W-1:0] rej_cnt;

  int n_chk = 0;
  int n_fail = 0;
  bit chk_en = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pulse_timebase #(.SEC_W(SEC_W), .TPS(TPS), .REJ_W(REJ_W)) dut_i (
    .clk_i (clk), .rst_ni (rst_n), .trig_i (trig),
    .pre_val_i (pre_val), .pre_we_i (pre_we), .min_gap_i (min_gap), .evt_i (evt),
    .time_sec_o (time_sec), .time_tick_o (time_tick),
    .cap_sec_o (cap_sec), .cap_tick_o (cap_tick),
    .trig_seen_o (seen), .pre_miss_o (pre_miss), .pulse_miss_o (pulse_miss),
    .rej_cnt_o (rej_cnt)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int          sq[$];
  longint      m_sec, m_pv, m_cap_sec;
  int          m_tick, m_gap, m_rej, m_cap_tick;
  bit          m_have, m_pend, m_seen, m_pm, m_wm;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sq = '{0, 0, 0};
      m_sec = 0; m_pv = 0; m_cap_sec = 0; m_tick = 0; m_gap = 0; m_rej = 0;
      m_cap_tick = 0; m_have = 0; m_pend = 0; m_seen = 0; m_pm = 0; m_wm = 0;
    end else begin
      bit edge_now, acc, rej, set_pm, set_wm;
      edge_now = (sq[1] == 1) && (sq[2] == 0);
      sq.push_front(int'(trig));
      void'(sq.pop_back());
      acc = edge_now && (!m_have || m_gap >= int'(min_gap));
      rej = edge_now && !acc;
      set_pm = 0; set_wm = 0;
      if (evt) begin m_cap_sec = m_sec; m_cap_tick = m_tick; end
      if (acc) begin
        if (m_pend) m_sec = m_pv;
        else begin m_sec = (m_sec + 1) % (64'd1 << SEC_W); set_pm = 1; end
        m_tick = 0; m_gap = 1; m_have = 1; m_seen = 1; m_pend = 0;
      end else begin
        if (m_tick == TPS - 1) begin
          m_tick = 0; m_sec = (m_sec + 1) % (64'd1 << SEC_W); set_wm = 1;
        end else m_tick++;
        if (m_gap < GAP_MAX) m_gap++;
      end
      if (rej && m_rej < REJ_MAX) m_rej++;
      if (pre_we) begin m_pv = pre_val; m_pend = 1; end
      if (set_pm) m_pm = 1; else if (pre_we) m_pm = 0;
      if (set_wm) m_wm = 1; else if (pre_we) m_wm = 0;
    end
  end

  always @(negedge clk) begin
    if (rst_n && chk_en) begin
      check(time_sec == m_sec[SEC_W-1:0], "R3", "time_sec", time_sec, m_sec);
      check(int'(time_tick) == m_tick, "R4", "time_tick", time_tick, m_tick);
      check(seen == m_seen, "R5", "trig_seen", seen, m_seen);
      check(pre_miss == m_pm, "R6", "pre_miss", pre_miss, m_pm);
      check(pulse_miss == m_wm, "R7", "pulse_miss", pulse_miss, m_wm);
      check(int'(rej_cnt) == m_rej, "R8", "rej_cnt", rej_cnt, m_rej);
      check(cap_sec == m_cap_sec[SEC_W-1:0] && int'(cap_tick) == m_cap_tick, "R9",
            "capture", {cap_sec, cap_tick}, {m_cap_sec[SEC_W-1:0], m_cap_tick[TW-1:0]});
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic preload(input longint v);
    pre_val = v[SEC_W-1:0]; pre_we = 1;
    cyc(1);
    pre_we = 0;
  endtask

  initial begin
    longint s0, s_cap;
    int     t_cap;
    min_gap = 20;
    cyc(3);
    check(time_sec == 0 && time_tick == 0 && cap_sec == 0 && cap_tick == 0, "R1",
          "time/capture in reset", {time_sec, time_tick}, 0);
    check(!seen && !pre_miss && !pulse_miss && rej_cnt == 0, "R1", "flags in reset",
          {seen, pre_miss, pulse_miss, rej_cnt}, 0);
    rst_n = 1; chk_en = 1;

    cyc(120);
    check(time_sec == 1 && pulse_miss, "R7", "free-run wrap", time_sec, 1);
    check(!seen, "R5", "no edge yet", seen, 0);

    preload(10);
    cyc(2);
    check(time_sec == 1, "R3", "write alone does not commit", time_sec, 1);

    trig = 1;
    cyc(2);
    check(time_sec == 1, "R2", "no commit before third edge", time_sec, 1);
    cyc(1);
    check(time_sec == 10 && time_tick == 0, "R2", "commit on third edge", time_sec, 10);
    check(seen, "R5", "seen after first edge", seen, 1);
    cyc(30);
    check(time_sec == 10 && time_tick == 30, "R2", "held-high single commit", time_tick, 30);
    trig = 0;

    cyc(30);
    trig = 1;
    cyc(3);
    check(time_sec == 11 && pre_miss, "R6", "edge without preload", time_sec, 11);
    cyc(2); trig = 0;
    preload(50);
    check(!pre_miss && !pulse_miss, "R6", "write clears missing flags",
          {pre_miss, pulse_miss}, 0);

    while (int'(time_tick) != TPS - 3) cyc(1);
    trig = 1;
    cyc(3);
    check(time_sec == 50 && time_tick == 0 && !pulse_miss, "R7",
          "edge on terminal tick wins", {time_sec, pulse_miss}, 100);
    cyc(1); trig = 0;

    min_gap = 90;
    s0 = time_sec;
    for (int i = 0; i < 10; i++) begin
      cyc(3); trig = 1; cyc(3); trig = 0;
    end
    cyc(3);
    check(int'(rej_cnt) == REJ_MAX, "R8", "rejections saturate", rej_cnt, REJ_MAX);
    check(time_sec == s0 && !pre_miss, "R8", "rejected edges leave time", time_sec, s0);

    s_cap = time_sec; t_cap = time_tick;
    evt = 1; cyc(1); evt = 0;
    check(cap_sec == s_cap && int'(cap_tick) == t_cap, "R9", "coherent capture",
          cap_tick, t_cap);

    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(0, 29) == 0) trig = ~trig;
      pre_we  = ($urandom_range(0, 39) == 0);
      pre_val = $urandom;
      evt     = ($urandom_range(0, 9) == 0);
      if (i % 500 == 0) min_gap = TW'($urandom_range(0, 80));
      cyc(1);
    end
    pre_we = 0; evt = 0;
    cyc(5);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule